// File: doc/BRIEF.md
# NAND Spare Area Repacker

This block is a byte-wide copy engine that sits between two on-chip memories of a NAND controller. One is a linear page buffer: the page data, followed directly by the out-of-band bytes as one contiguous array. The other is the controller's spare RAM. The spare RAM gives each 512-byte section of the page its own 16-byte slot. After a page has been read from flash, the engine unpacks the spare slots into the linear array. Before a program, it packs the linear array into the slots.

The out-of-band bytes are split into equal chunks, one chunk per section. Each chunk is the out-of-band size divided by the section count, rounded down to an even value. The final section takes whatever bytes are left. Chunk i starts at slot base i·16 in the spare RAM and at offset pageSize + i·chunk in the linear buffer. A start pulse loads the page size, the out-of-band size and the direction. The engine then moves one byte per clock over the memories' read and write ports and pulses done at the end.

Top module: `oob_spare_repacker`

## Requirements
- R1: The section count is pageSize/512. pageSize must be 512·2^k with 2^k no larger than MAX_PAGE/512.
- R2: Every section except the last gets a chunk of floor(oobSize/sections) rounded down to an even byte count.
- R3: Byte b of chunk i sits at linear address pageSize + i·chunk + b and at spare address i·16 + b. The linear addresses therefore always lie at or above pageSize.
- R4: The last section moves oobSize − (sections−1)·chunk bytes. When the chunk is zero, all oobSize bytes go to the last slot, starting at spare address (sections−1)·16.
- R5: With packMode = 0 (unpack), only spare RAM is read and only the linear buffer is written. With packMode = 1 (pack), only the linear buffer is read and only spare RAM is written.
- R6: Both memories have a one-cycle read latency. A start sampled at edge E0 issues one read per cycle in the oobSize cycles that follow, in increasing linear order. Each read's write occurs in the next cycle, carrying the read data.
- R7: done is high for exactly one cycle, the cycle after the last write, that is oobSize+2 cycles after E0. With oobSize = 0, done rises one cycle after E0 and no memory is accessed.
- R8: A start pulse that arrives before done has been given is ignored. It causes no extra reads or writes and no second done, and a change of direction or size at that time has no effect.
- R9: Only the addresses listed in R3/R4 are written. Slot bytes past a chunk's length and the page data region stay unchanged.
- R10: While reset is applied and after it is released, all enables and done are low until a start is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| start | input | 1 | One-cycle request to begin a transfer |
| packMode | input | 1 | 1 = linear to spare (pack), 0 = spare to linear (unpack) |
| pageSize | input | 12 | Page data size in bytes, 512·2^k |
| oobSize | input | 8 | Out-of-band byte count |
| linRdEn | output | 1 | Linear buffer read enable |
| linRdAddr | output | 12 | Linear buffer read address |
| linRdData | input | 8 | Linear buffer read data, one cycle after linRdEn |
| linWrEn | output | 1 | Linear buffer write enable |
| linWrAddr | output | 12 | Linear buffer write address |
| linWrData | output | 8 | Linear buffer write data |
| spRdEn | output | 1 | Spare RAM read enable |
| spRdAddr | output | 6 | Spare RAM read address |
| spRdData | input | 8 | Spare RAM read data, one cycle after spRdEn |
| spWrEn | output | 1 | Spare RAM write enable |
| spWrAddr | output | 6 | Spare RAM write address |
| spWrData | output | 8 | Spare RAM write data |
| done | output | 1 | One-cycle completion pulse |

## Verification
The bench runs both directions on a 2048-byte page with 64 out-of-band bytes, where every chunk fills its slot exactly. It then runs 58 bytes, where the chunk of 14 leaves two slot bytes untouched and the last section takes 16. A 1024-byte page with 27 bytes exercises rounding down to an even chunk and an odd-length last section. A single-section 512-byte page and a 3-byte case, where the chunk is zero and everything lands in the last slot, separate the last-section logic from the general stride. An empty transfer and a start pulse with a flipped direction in mid-run test the done timing and that the engine ignores requests while busy.

// File: rtl/oob_repack_pkg.sv
package oob_repack_pkg;
  localparam int SLOT_SHIFT    = 4;   // 16-byte spare slot per section
  localparam int SECTION_SHIFT = 9;   // 512-byte sections

  typedef struct packed {
    logic load;        // latch configuration, reset pointers
    logic skipToLast;  // with load: chunk is zero, start at final slot
    logic rd;          // issue one read and advance pointers
    logic sectEnd;     // with rd: this byte closes its section
    logic pack;        // direction of the current transfer
  } oobStrobe_t;
endpackage

// File: rtl/oob_repack_ctrl.sv
module oob_repack_ctrl
  import oob_repack_pkg::*;
#(
  parameter int SECT_W = 2,
  parameter int OOB_W  = 8,
  parameter int PAGE_W = 12,
  parameter int KW     = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic              packMode,
  input  logic [PAGE_W-1:0] pageSize,
  input  logic [OOB_W-1:0]  oobSize,
  output oobStrobe_t        stb,
  output logic [SECT_W-1:0] lastSect,
  output logic              done
);
  typedef enum logic [1:0] {IDLE, RUN, TAIL, FIN} state_t;

  state_t            state;
  logic              packQ;
  logic [OOB_W-1:0]  chunkQ, leftQ, byteQ;
  logic [SECT_W-1:0] sectQ, lastIdxQ;

  logic [KW-1:0]     kIn;
  logic [SECT_W:0]   nSect;
  logic [OOB_W-1:0]  chunkIn;
  logic              accept, isLast, chunkEnd;

  // section count exponent from the single set bit of pageSize above bit 8
  always_comb begin
    kIn = '0;
    for (int i = 0; i <= SECT_W; i++)
      if (pageSize[SECTION_SHIFT+i]) kIn = KW'(i);
  end

  assign nSect    = (SECT_W+1)'(1) << kIn;
  assign lastSect = SECT_W'(nSect - (SECT_W+1)'(1));
  assign chunkIn  = (oobSize >> kIn) & ~OOB_W'(1);
  assign accept   = (state == IDLE) && start;
  assign isLast   = (sectQ == lastIdxQ);
  assign chunkEnd = (OOB_W'(byteQ + OOB_W'(1)) == chunkQ);

  always_comb begin
    stb            = '0;
    stb.pack       = packQ;
    stb.load       = accept;
    stb.skipToLast = accept && (chunkIn == '0);
    stb.rd         = (state == RUN);
    stb.sectEnd    = (state == RUN) && !isLast && chunkEnd;
  end

  assign done = (state == FIN);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= IDLE;
      packQ    <= 1'b0;
      chunkQ   <= '0;
      leftQ    <= '0;
      byteQ    <= '0;
      sectQ    <= '0;
      lastIdxQ <= '0;
    end else begin
      case (state)
        IDLE: if (start) begin
          packQ    <= packMode;
          chunkQ   <= chunkIn;
          leftQ    <= oobSize;
          byteQ    <= '0;
          lastIdxQ <= lastSect;
          sectQ    <= (chunkIn == '0) ? lastSect : '0;
          state    <= (oobSize == '0) ? FIN : RUN;
        end
        RUN: begin
          leftQ <= leftQ - OOB_W'(1);
          if (isLast) begin
            byteQ <= byteQ + OOB_W'(1);
            if (leftQ == OOB_W'(1)) state <= TAIL;
          end else if (chunkEnd) begin
            byteQ <= '0;
            sectQ <= sectQ + SECT_W'(1);
          end else begin
            byteQ <= byteQ + OOB_W'(1);
          end
        end
        TAIL:    state <= FIN;
        default: state <= IDLE;
      endcase
    end
  end
endmodule

// File: rtl/oob_repack_dp.sv
module oob_repack_dp
  import oob_repack_pkg::*;
#(
  parameter int SECT_W = 2,
  parameter int PAGE_W = 12,
  parameter int LIN_AW = 12,
  parameter int SP_AW  = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  oobStrobe_t        stb,
  input  logic [SECT_W-1:0] lastSect,
  input  logic [PAGE_W-1:0] pageSize,
  output logic              linRdEn,
  output logic [LIN_AW-1:0] linRdAddr,
  input  logic [7:0]        linRdData,
  output logic              linWrEn,
  output logic [LIN_AW-1:0] linWrAddr,
  output logic [7:0]        linWrData,
  output logic              spRdEn,
  output logic [SP_AW-1:0]  spRdAddr,
  input  logic [7:0]        spRdData,
  output logic              spWrEn,
  output logic [SP_AW-1:0]  spWrAddr,
  output logic [7:0]        spWrData
);
  localparam logic [SP_AW-1:0] SLOT_STEP = SP_AW'(1 << SLOT_SHIFT);

  logic [LIN_AW-1:0] linPtr, wrLinA;
  logic [SP_AW-1:0]  spBase, spPtr, wrSpA, startBase;
  logic              wrPend, wrPack;

  assign startBase = stb.skipToLast ? {lastSect, SLOT_SHIFT'(0)} : '0;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      linPtr <= '0;
      spBase <= '0;
      spPtr  <= '0;
      wrPend <= 1'b0;
      wrPack <= 1'b0;
      wrLinA <= '0;
      wrSpA  <= '0;
    end else begin
      if (stb.load) begin
        linPtr <= LIN_AW'(pageSize);
        spBase <= startBase;
        spPtr  <= startBase;
      end else if (stb.rd) begin
        linPtr <= linPtr + LIN_AW'(1);
        if (stb.sectEnd) begin
          spBase <= spBase + SLOT_STEP;
          spPtr  <= spBase + SLOT_STEP;
        end else begin
          spPtr  <= spPtr + SP_AW'(1);
        end
      end
      wrPend <= stb.rd;
      wrPack <= stb.pack;
      wrLinA <= linPtr;
      wrSpA  <= spPtr;
    end
  end

  assign linRdEn   = stb.rd && stb.pack;
  assign spRdEn    = stb.rd && !stb.pack;
  assign linRdAddr = linPtr;
  assign spRdAddr  = spPtr;

  assign linWrEn   = wrPend && !wrPack;
  assign linWrAddr = wrLinA;
  assign linWrData = spRdData;
  assign spWrEn    = wrPend && wrPack;
  assign spWrAddr  = wrSpA;
  assign spWrData  = linRdData;
endmodule

// File: rtl/oob_spare_repacker.sv
module oob_spare_repacker
  import oob_repack_pkg::*;
#(
  parameter int MAX_PAGE = 2048,
  parameter int OOB_W    = 8,
  localparam int MAX_SECT = MAX_PAGE >> SECTION_SHIFT,
  localparam int SECT_W   = (MAX_SECT > 1) ? $clog2(MAX_SECT) : 1,
  localparam int PAGE_W   = SECTION_SHIFT + SECT_W + 1,
  localparam int LIN_AW   = $clog2(MAX_PAGE + (1 << OOB_W)),
  localparam int SP_AW    = SECT_W + SLOT_SHIFT,
  localparam int KW       = $clog2(SECT_W + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic              packMode,
  input  logic [PAGE_W-1:0] pageSize,
  input  logic [OOB_W-1:0]  oobSize,
  output logic              linRdEn,
  output logic [LIN_AW-1:0] linRdAddr,
  input  logic [7:0]        linRdData,
  output logic              linWrEn,
  output logic [LIN_AW-1:0] linWrAddr,
  output logic [7:0]        linWrData,
  output logic              spRdEn,
  output logic [SP_AW-1:0]  spRdAddr,
  input  logic [7:0]        spRdData,
  output logic              spWrEn,
  output logic [SP_AW-1:0]  spWrAddr,
  output logic [7:0]        spWrData,
  output logic              done
);
  oobStrobe_t        stb;
  logic [SECT_W-1:0] lastSect;

  oob_repack_ctrl #(.SECT_W(SECT_W), .OOB_W(OOB_W), .PAGE_W(PAGE_W), .KW(KW)) u_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .packMode(packMode),
    .pageSize(pageSize), .oobSize(oobSize),
    .stb(stb), .lastSect(lastSect), .done(done)
  );

  oob_repack_dp #(.SECT_W(SECT_W), .PAGE_W(PAGE_W), .LIN_AW(LIN_AW), .SP_AW(SP_AW)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .lastSect(lastSect), .pageSize(pageSize),
    .linRdEn(linRdEn), .linRdAddr(linRdAddr), .linRdData(linRdData),
    .linWrEn(linWrEn), .linWrAddr(linWrAddr), .linWrData(linWrData),
    .spRdEn(spRdEn), .spRdAddr(spRdAddr), .spRdData(spRdData),
    .spWrEn(spWrEn), .spWrAddr(spWrAddr), .spWrData(spWrData)
  );
endmodule

// File: rtl/oob_repack_checker.sv
module oob_repack_checker #(
  parameter int PAGE_W = 12,
  parameter int LIN_AW = 12
) (
  input logic              clk,
  input logic              rstN,
  input logic [PAGE_W-1:0] pageSize,
  input logic              linRdEn,
  input logic              linWrEn,
  input logic [LIN_AW-1:0] linWrAddr,
  input logic              spRdEn,
  input logic              spWrEn,
  input logic              done
);
  AST_ONE_SOURCE: assert property (@(posedge clk) disable iff (!rstN)
    !(linRdEn && spRdEn));  // R5
  AST_LIN_WR_FROM_SPARE: assert property (@(posedge clk) disable iff (!rstN)
    linWrEn |-> $past(spRdEn));  // R6
  AST_SP_WR_FROM_LIN: assert property (@(posedge clk) disable iff (!rstN)
    spWrEn |-> $past(linRdEn));  // R5
  AST_SINGLE_DEST: assert property (@(posedge clk) disable iff (!rstN)
    !(linWrEn && spWrEn));  // R5
  AST_LIN_ABOVE_PAGE: assert property (@(posedge clk) disable iff (!rstN)
    linWrEn |-> (32'(linWrAddr) >= 32'(pageSize)));  // R3
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);  // R7
  AST_DONE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !(linRdEn || spRdEn || linWrEn || spWrEn));  // R7
  AST_NO_TRAFFIC_AFTER_DONE: assert property (@(posedge clk) disable iff (!rstN)
    $past(done) |-> !(linWrEn || spWrEn));  // R8
endmodule

bind oob_spare_repacker oob_repack_checker #(.PAGE_W(PAGE_W), .LIN_AW(LIN_AW)) u_chk (
  .clk(clk), .rstN(rstN), .pageSize(pageSize),
  .linRdEn(linRdEn), .linWrEn(linWrEn), .linWrAddr(linWrAddr),
  .spRdEn(spRdEn), .spWrEn(spWrEn), .done(done)
);

// File: tb/test_oob_spare_repacker.sv
module test_oob_spare_repacker;
  localparam int LIN_N = 2304;
  localparam int SP_N  = 64;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic        packMode = 1'b0;
  logic [11:0] pageSize = 12'd2048;
  logic [7:0]  oobSize = 8'd0;
  logic        linRdEn, linWrEn, spRdEn, spWrEn, done;
  logic [11:0] linRdAddr, linWrAddr;
  logic [5:0]  spRdAddr, spWrAddr;
  logic [7:0]  linRdData, linWrData, spRdData, spWrData;

  always #10 clk = ~clk;  // 50 MHz

  oob_spare_repacker i_oob_spare_repacker (
    .clk(clk), .rstN(rstN), .start(start), .packMode(packMode),
    .pageSize(pageSize), .oobSize(oobSize),
    .linRdEn(linRdEn), .linRdAddr(linRdAddr), .linRdData(linRdData),
    .linWrEn(linWrEn), .linWrAddr(linWrAddr), .linWrData(linWrData),
    .spRdEn(spRdEn), .spRdAddr(spRdAddr), .spRdData(spRdData),
    .spWrEn(spWrEn), .spWrAddr(spWrAddr), .spWrData(spWrData),
    .done(done)
  );

  // memory models with one-cycle read latency
  logic [7:0] linMem [LIN_N];
  logic [7:0] spMem  [SP_N];
  logic [7:0] expLin [LIN_N];
  logic [7:0] expSp  [SP_N];

  always @(posedge clk) begin
    if (linRdEn) linRdData <= linMem[linRdAddr];
    if (spRdEn)  spRdData  <= spMem[spRdAddr];
    if (linWrEn) linMem[linWrAddr] <= linWrData;
    if (spWrEn)  spMem[spWrAddr]   <= spWrData;
  end

  typedef struct {
    bit toLin;
    int addr;
    int data;
  } wrItem_t;

  wrItem_t expQ[$];
  int total = 0;
  int bad = 0;
  int seed = 1;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // monitor: pops the scoreboard on every write
  always @(negedge clk) begin
    if (rstN && (linWrEn || spWrEn)) begin
      int aA, aD;
      aA = linWrEn ? int'(linWrAddr) : int'(spWrAddr);
      aD = linWrEn ? int'(linWrData) : int'(spWrData);
      total++;
      if (expQ.size() == 0) begin
        bad++;
        $display("FAIL R8 unexpected write actual=%0d expected=none", aA);
      end else begin
        wrItem_t it;
        it = expQ.pop_front();
        if (linWrEn !== it.toLin || spWrEn === linWrEn || aA != it.addr || aD != it.data) begin
          bad++;
          $display("FAIL R3 write lin=%0b addr/data actual=%0d/%0d expected lin=%0b %0d/%0d",
                   linWrEn, aA, aD, it.toLin, it.addr, it.data);
        end
      end
    end
  end

  // driver: build expectations from R1..R4, run one transfer, check timing and images
  task automatic runOp(input int pg, input int oob, input bit pk, input bit poke, input string tag);
    int n, j, len, cyc, expCyc, misL, misS;
    n = pg / 512;
    j = ((oob / n) / 2) * 2;
    seed++;
    for (int a = 0; a < LIN_N; a++) begin
      linMem[a] = 8'(a * 7 + seed * 31 + 3);
      expLin[a] = linMem[a];
    end
    for (int a = 0; a < SP_N; a++) begin
      spMem[a] = 8'(a * 11 + seed * 17 + 129);
      expSp[a] = spMem[a];
    end
    for (int i = 0; i < n; i++) begin
      len = (i == n - 1) ? oob - (n - 1) * j : j;
      for (int b = 0; b < len; b++) begin
        int la, sa;
        wrItem_t it;
        la = pg + i * j + b;
        sa = i * 16 + b;
        if (pk) begin
          it.toLin = 1'b0; it.addr = sa; it.data = int'(linMem[la]);
          expSp[sa] = linMem[la];
        end else begin
          it.toLin = 1'b1; it.addr = la; it.data = int'(spMem[sa]);
          expLin[la] = spMem[sa];
        end
        expQ.push_back(it);
      end
    end
    expCyc = (oob == 0) ? 1 : oob + 2;

    @(negedge clk);
    pageSize = 12'(pg); oobSize = 8'(oob); packMode = pk; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    cyc = 1;
    forever begin
      if (done || cyc > 600) break;
      if (poke && cyc == 3) begin
        start = 1'b1; packMode = ~pk; oobSize = 8'(oob / 2);  // R8 poke while busy
      end else begin
        start = 1'b0;
      end
      @(negedge clk);
      cyc++;
    end
    start = 1'b0;
    chk(cyc == expCyc, {"R7 done latency ", tag}, cyc, expCyc);
    chk(expQ.size() == 0, {"R6 all writes seen ", tag}, expQ.size(), 0);
    @(negedge clk);
    chk(done == 1'b0, {"R7 done one cycle ", tag}, int'(done), 0);
    misL = 0; misS = 0;
    for (int a = 0; a < LIN_N; a++) if (linMem[a] !== expLin[a]) misL++;
    for (int a = 0; a < SP_N; a++)  if (spMem[a] !== expSp[a]) misS++;
    chk(misL == 0, {"R9 linear image ", tag}, misL, 0);
    chk(misS == 0, {"R9 spare image ", tag}, misS, 0);
    repeat (5) begin
      @(negedge clk);
      if (done) chk(1'b0, {"R8 second done ", tag}, 1, 0);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R10: quiet during reset
    chk(!(linRdEn || spRdEn || linWrEn || spWrEn || done), "R10 quiet in reset", 1, 0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    chk(!(linRdEn || spRdEn || linWrEn || spWrEn || done), "R10 quiet after reset", 1, 0);

    runOp(2048, 64, 1'b0, 1'b0, "R1 unpack 2k/64");
    runOp(2048, 64, 1'b1, 1'b0, "R5 pack 2k/64");
    runOp(2048, 58, 1'b1, 1'b0, "R2 pack 2k/58 slot tails");
    runOp(2048, 58, 1'b0, 1'b0, "R4 unpack 2k/58");
    runOp(512, 16, 1'b1, 1'b0, "R1 single section");
    runOp(1024, 27, 1'b0, 1'b0, "R2 odd 1k/27");
    runOp(2048, 3, 1'b1, 1'b0, "R4 zero chunk pack");
    runOp(2048, 3, 1'b0, 1'b0, "R4 zero chunk unpack");
    runOp(2048, 0, 1'b1, 1'b0, "R7 empty");
    runOp(2048, 64, 1'b0, 1'b1, "R8 start while busy");

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule